// File: doc/BRIEF.md
# Timer Input Capture Unit

This unit watches one external input and records the time at which a chosen event occurs on it. It takes the count of one of two free-running 16-bit timers at that moment and holds it in a 16-bit capture register. A sticky flag tells software that a new value is present. The qualifying event can be a falling edge, a rising edge, every fourth rising edge or every sixteenth rising edge. A 4-bit mode field selects the event and also turns the unit on and off.

The input pin is asynchronous. It passes through a synchronizer before edge detection, so each transition of the pin yields exactly one edge pulse. A prescaler counts qualifying edges. The prescaler loses its count only while the unit is disabled. A direct change from one enabled setting to another keeps the partial count, and it raises the flag once. Software clears the flag with a one-cycle strobe. A capture that lands before software has read the register simply replaces the old value.

All pins are plain control and status signals. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure. The register and the flag are levels that software may sample at any time.

Top module: `capt_unit`

## Requirements
- R1: The mode field `mode_i` decodes as 4'b0000 = off, 4'b0100 = every falling edge, 4'b0101 = every rising edge, 4'b0110 = every 4th rising edge, 4'b0111 = every 16th rising edge. Every other value disables capture. While capture is disabled, `capture_o` does not change and no capture sets the flag.
- R2: The pin goes through a two-flop synchronizer. A pin level that is set up before rising clock edge A counts as a transition at edge A. The capture for that transition loads `capture_o` at edge A+2, and each transition yields at most one capture.
- R3: On a capture, `capture_o` takes the full 16-bit value present at that clock edge on `timer_a_i` when `tmr_sel_i`=0, or on `timer_b_i` when `tmr_sel_i`=1.
- R4: A capture sets `flag_o` at the same edge that loads `capture_o`. The flag then stays at 1 until a clear strobe.
- R5: A second capture overwrites `capture_o` whether or not the flag is still set. No error is signalled.
- R6: `flag_clr_i`=1 for one cycle clears `flag_o` at the next edge. If a capture or a mode switch occurs in that same cycle, the flag ends up at 1.
- R7: The prescaler counts qualifying edges in every enabled mode. In the every-4th mode a capture occurs when the count before the edge has its low two bits equal to 3. In the every-16th mode a capture occurs when that 4-bit count equals 15. The count resets to zero at reset and in every cycle in which capture is disabled.
- R8: If `mode_i` changes directly from one enabled value to another enabled value, the prescaler count is kept. The flag is set at the first edge that sees the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | Asynchronous capture input |
| mode_i | input | 4 | Mode and event select |
| tmr_sel_i | input | 1 | Timer source select (0 = A, 1 = B) |
| timer_a_i | input | 16 | Count of timer A |
| timer_b_i | input | 16 | Count of timer B |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| capture_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture flag |

## Verification
A wrong prescaler count does not show up at once. It shows up as a capture that comes early or late: up to fifteen qualifying edges late in the every-16th mode, or as a surprise capture right after a mode switch. A fault in the synchronizer or the edge detector moves a capture by one cycle. It can also double a capture or drop one, and `capture_o` then holds a neighbouring timer value at the third edge after a pin change. Flag faults appear within one cycle of a clear strobe or a capture. The bench therefore compares `capture_o` and `flag_o` against a behavioural model on every clock.

// File: rtl/capt_pkg.sv
package capt_pkg;
  typedef struct packed {
    logic       en;
    logic       falling;
    logic [2:0] div_log;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [3:0] m);
    mode_dec_t d;
    d = '0;
    unique case (m)
      4'b0100: begin d.en = 1'b1; d.falling = 1'b1; d.div_log = 3'd0; end
      4'b0101: begin d.en = 1'b1; d.div_log = 3'd0; end
      4'b0110: begin d.en = 1'b1; d.div_log = 3'd2; end
      4'b0111: begin d.en = 1'b1; d.div_log = 3'd4; end
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/capt_edge_sync.sv
module capt_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] stg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= 1'b0;
    else        stg_q[0] <= pin_i;
  end

  for (genvar i = 1; i <= STAGES; i++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[i] <= 1'b0;
      else        stg_q[i] <= stg_q[i-1];
    end
  end

  assign rise_o = stg_q[STAGES-1] & ~stg_q[STAGES];
  assign fall_o = ~stg_q[STAGES-1] & stg_q[STAGES];
endmodule

// File: rtl/capt_prescale.sv
module capt_prescale #(
  parameter int CNT_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       qual_i,
  input  logic [2:0] div_log_i,
  output logic       event_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < CNT_W; b++)
      if (b < int'(div_log_i)) mask[b] = 1'b1;
  end

  assign event_o = en_i && qual_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (qual_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/capt_latch.sv
module capt_latch #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          event_i,
  input  logic          switch_i,
  input  logic          clr_i,
  input  logic [TW-1:0] value_i,
  output logic [TW-1:0] cap_o,
  output logic          flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (event_i) cap_o <= value_i;
      flag_o <= event_i | switch_i | (flag_o & ~clr_i);
    end
  end
endmodule

// File: rtl/capt_unit.sv
module capt_unit
  import capt_pkg::*;
#(
  parameter int TW          = 16,
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_pin_i,
  input  logic [3:0]    mode_i,
  input  logic          tmr_sel_i,
  input  logic [TW-1:0] timer_a_i,
  input  logic [TW-1:0] timer_b_i,
  input  logic          flag_clr_i,
  output logic [TW-1:0] capture_o,
  output logic          flag_o
);
  mode_dec_t dec_now, dec_prev;
  logic [3:0] mode_q;
  logic rise_w, fall_w, qual_w, ev_w, sw_w;
  logic [TW-1:0] src_w;

  assign dec_now  = decode_mode(mode_i);
  assign dec_prev = decode_mode(mode_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 4'b0000;
    else        mode_q <= mode_i;
  end

  assign sw_w   = dec_now.en && dec_prev.en && (mode_i != mode_q);
  assign qual_w = dec_now.falling ? fall_w : rise_w;
  assign src_w  = tmr_sel_i ? timer_b_i : timer_a_i;

  capt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_pin_i),
    .rise_o(rise_w), .fall_o(fall_w)
  );

  capt_prescale #(.CNT_W(CNT_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .en_i(dec_now.en), .qual_i(qual_w),
    .div_log_i(dec_now.div_log), .event_o(ev_w)
  );

  capt_latch #(.TW(TW)) u_latch (
    .clk(clk), .rst_n(rst_n), .event_i(ev_w), .switch_i(sw_w),
    .clr_i(flag_clr_i), .value_i(src_w), .cap_o(capture_o), .flag_o(flag_o)
  );
endmodule

// File: rtl/capt_unit_chk.sv
module capt_unit_chk #(
  parameter int TW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    mode_i,
  input logic          tmr_sel_i,
  input logic [TW-1:0] timer_a_i,
  input logic [TW-1:0] timer_b_i,
  input logic          flag_clr_i,
  input logic [TW-1:0] capture_o,
  input logic          flag_o,
  input logic          ev,
  input logic          sw
);
  logic mode_on;
  assign mode_on = (mode_i[3:2] == 2'b01);

  AST_OFF_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> $stable(capture_o)); // R1
  AST_CAP_TIMER_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && !tmr_sel_i) |=> (capture_o == $past(timer_a_i))); // R3
  AST_CAP_TIMER_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ev && tmr_sel_i) |=> (capture_o == $past(timer_b_i))); // R3
  AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ev |=> flag_o); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o); // R4
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr_i && !ev && !sw) |=> !flag_o); // R6
  AST_SWITCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    sw |=> flag_o); // R8
endmodule

bind capt_unit capt_unit_chk #(.TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .tmr_sel_i(tmr_sel_i),
  .timer_a_i(timer_a_i), .timer_b_i(timer_b_i), .flag_clr_i(flag_clr_i),
  .capture_o(capture_o), .flag_o(flag_o), .ev(ev_w), .sw(sw_w)
);

// File: tb/capt_unit_tb.sv
module capt_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin = 1'b0;
  logic [3:0] mode = 4'b0000;
  logic sel = 1'b0;
  logic [15:0] ta = 16'h0, tb = 16'hffff;
  logic clr = 1'b0;
  logic [15:0] cap;
  logic flag;

  always #2.5 clk = ~clk;

  capt_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cap_pin_i(pin), .mode_i(mode), .tmr_sel_i(sel),
    .timer_a_i(ta), .timer_b_i(tb), .flag_clr_i(clr),
    .capture_o(cap), .flag_o(flag)
  );

  int total = 0, bad = 0, cyc = 0;
  string req = "R1";
  bit done = 1'b0;

  // behavioural reference
  bit hist[$] = '{0, 0, 0};
  int m_cnt = 0;
  int m_cap = 0;
  bit m_flag = 0;
  logic [3:0] m_prev = 4'b0000;

  function automatic bit on(input logic [3:0] m);
    return (m == 4'b0100) || (m == 4'b0101) || (m == 4'b0110) || (m == 4'b0111);
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      hist = '{0, 0, 0}; m_cnt = 0; m_cap = 0; m_flag = 0; m_prev = 4'b0000;
    end else begin
      bit rise, fall, qual, ev, sw;
      int period;
      rise = hist[1] && !hist[2];
      fall = !hist[1] && hist[2];
      qual = on(mode) && ((mode == 4'b0100) ? fall : rise);
      period = (mode == 4'b0110) ? 4 : (mode == 4'b0111) ? 16 : 1;
      ev = qual && ((m_cnt % period) == period - 1);
      sw = on(mode) && on(m_prev) && (mode != m_prev);
      if (ev) m_cap = sel ? int'(tb) : int'(ta);
      m_flag = ev || sw || (m_flag && !clr);
      if (!on(mode)) m_cnt = 0;
      else if (qual) m_cnt = (m_cnt + 1) % 16;
      m_prev = mode;
      hist.push_front(pin);
      hist = hist[0:2];
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (cap !== m_cap[15:0] || flag !== m_flag) begin
        bad++;
        $display("FAIL %s cycle %0d: cap=%h flag=%b expected cap=%h flag=%b",
                 req, cyc, cap, flag, m_cap[15:0], m_flag);
      end
    end
    ta <= ta + 16'd1;
    tb <= tb - 16'd3;
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic toggle(input int hi, input int lo);
    @(negedge clk) pin = 1'b1; wait_cyc(hi);
    pin = 1'b0; wait_cyc(lo);
  endtask

  task automatic clear_flag;
    @(negedge clk) clr = 1'b1;
    @(negedge clk) clr = 1'b0;
  endtask

  initial begin
    wait_cyc(4);
    total++;
    if (cap !== 16'h0 || flag !== 1'b0) begin
      bad++; $display("FAIL R4 reset: cap=%h flag=%b expected 0000/0", cap, flag);
    end
    rst_n = 1'b1;
    req = "R1 off"; for (int i = 0; i < 4; i++) toggle(3, 3);
    req = "R1 invalid"; mode = 4'b1101; for (int i = 0; i < 3; i++) toggle(2, 4);
    mode = 4'b0000; wait_cyc(2);
    req = "R2 rising"; mode = 4'b0101; for (int i = 0; i < 3; i++) toggle(4, 5);
    req = "R2 falling"; mode = 4'b0000; wait_cyc(1); mode = 4'b0100;
    for (int i = 0; i < 3; i++) toggle(6, 2);
    req = "R3 timer B"; sel = 1'b1; toggle(3, 3); sel = 1'b0; toggle(3, 3);
    req = "R5 overwrite"; toggle(1, 1); toggle(1, 1);
    req = "R6 clear"; clear_flag(); wait_cyc(3);
    req = "R6 clear race";
    for (int d = 0; d < 6; d++) begin
      @(negedge clk) pin = 1'b1;
      wait_cyc(d); clr = 1'b1; @(negedge clk) clr = 1'b0;
      wait_cyc(4); pin = 1'b0; wait_cyc(4);
    end
    req = "R7 div4"; mode = 4'b0000; wait_cyc(1); mode = 4'b0110; clear_flag();
    for (int i = 0; i < 10; i++) toggle(2, 2);
    req = "R7 div16"; mode = 4'b0000; wait_cyc(1); mode = 4'b0111; clear_flag();
    for (int i = 0; i < 35; i++) toggle(1, 2);
    req = "R7 off clears"; for (int i = 0; i < 7; i++) toggle(1, 2);
    mode = 4'b0000; wait_cyc(2); mode = 4'b0111;
    for (int i = 0; i < 17; i++) toggle(1, 2);
    req = "R8 switch"; clear_flag();
    for (int i = 0; i < 5; i++) toggle(2, 2);
    mode = 4'b0110; wait_cyc(3); clear_flag();
    for (int i = 0; i < 6; i++) toggle(2, 2);
    mode = 4'b0101; wait_cyc(2); mode = 4'b0100; wait_cyc(2); clear_flag();
    toggle(3, 3);
    req = "R1 off hold"; mode = 4'b0000; clear_flag();
    for (int i = 0; i < 3; i++) toggle(2, 2);
    wait_cyc(4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    done = 1'b1;
    total++; bad++;
    $display("FAIL watchdog during %s: run did not end, expected completion", req);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule